// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block is the controller-side state machine that takes an SDRAM from power-on to a state where normal traffic may begin. It keeps the command bus deselected until the clock is reported stable. It then holds NOP for the power-up delay, precharges every bank, issues two auto-refresh commands and writes the mode register. After each command it inserts NOP cycles so that the next command respects the device's recovery time. After the last wait it raises a done flag that the rest of the controller uses to start its own traffic.

All delays are parameters in nanoseconds or cycles and are converted to clock counts from the clock frequency when the block is elaborated. The mode word is also assembled from parameters: burst length code, burst type, CAS latency and write-burst mode. The operating-mode and reserved bits are always zero. A synchronous reset sends the block back to its first state from any point in the sequence.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst` is high, and after it until `clk_stable` is sampled high, the block drives command inhibit. That means all four command pins are 1, address and bank are 0, and `init_done` is 0.
- R2: At the first rising edge after reset where `clk_stable` is 1, the block starts NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1). The NOP lasts exactly PWR = ceil(T_POWERUP_NS*CLK_MHZ/1000) cycles, with address 0.
- R3: PRECHARGE-all follows the power-up NOPs as a single cycle (0,0,1,0). Address bit AP_BIT (10) is 1, all other address bits are 0, and bank is 0.
- R4: The next command starts RP = max(ceil(T_RP_NS*CLK_MHZ/1000), 2) cycles after the precharge cycle. The cycles in between are NOP.
- R5: Exactly two AUTO REFRESH cycles (0,0,0,1) are issued with address 0 and bank 0. Each one is followed by RC = max(ceil(T_RC_NS*CLK_MHZ/1000), 2) cycles before the next command, filled with NOP.
- R6: LOAD MODE (0,0,0,0) follows the second refresh wait, with bank 0. The address carries the burst length code in bits 2..0, the burst type in bit 3, the CAS latency in bits 6..4 and the write-burst mode in bit 9. Bits 8..7, 11..10 and all higher bits are 0.
- R7: The cycles after LOAD MODE are NOP. `init_done` rises exactly T_MRD_CYC cycles after the LOAD MODE cycle.
- R8: Once `init_done` is 1, it stays 1 and the bus stays at NOP until reset.
- R9: Once the power-up wait has started, `clk_stable` has no effect on the sequence.
- R10: A reset at any point in the sequence, including while a refresh is on the bus or after completion, restarts the sequence from R1. This includes the full power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_stable | input | 1 | High once the clock to the memory is stable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address pins (precharge-all flag, mode word) |
| sd_bank | output | BANK_W | Bank select pins |
| init_done | output | 1 | Initialization complete |

## Verification
Reset and command issue can land in the same cycle. The bench watches the bus and raises reset on the negative edge where the second refresh is visible, so the reset is sampled at the very edge that would end that refresh. The restarted run must then show inhibit followed by a complete power-up wait. Reset release and `clk_stable` can also coincide. The bench releases reset with `clk_stable` already high, and the queue-based reference model must see NOP begin on the very next edge.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   typedef enum logic [3:0] {
      S_WAIT_CLK,
      S_POWERUP,
      S_PRECHARGE,
      S_WAIT_RP,
      S_REF_A,
      S_WAIT_RC_A,
      S_REF_B,
      S_WAIT_RC_B,
      S_LOAD_MODE,
      S_WAIT_MRD,
      S_READY
   } init_state_e;

   // {cs_n, ras_n, cas_n, we_n}
   typedef logic [3:0] sd_cmd_t;

   localparam sd_cmd_t CMD_INHIBIT   = 4'b1111;
   localparam sd_cmd_t CMD_NOP       = 4'b0111;
   localparam sd_cmd_t CMD_PRECHARGE = 4'b0010;
   localparam sd_cmd_t CMD_REFRESH   = 4'b0001;
   localparam sd_cmd_t CMD_LOAD_MODE = 4'b0000;

   // Round a delay up to whole cycles, never below a floor.
   function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                input int unsigned mhz,
                                                input int unsigned floor_cyc);
      int unsigned c;
      c = (ns * mhz + 999) / 1000;
      return (c < floor_cyc) ? floor_cyc : c;
   endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
   parameter int CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_mode_word.sv
module sdram_init_mode_word #(
   parameter int         ADDR_W      = 12,
   parameter logic [2:0] BL_CODE     = 3'd3,
   parameter logic       BURST_TYPE  = 1'b0,
   parameter logic [2:0] CAS_LAT     = 3'd3,
   parameter logic       WRITE_BURST = 1'b0
) (
   output logic [ADDR_W-1:0] word
);

   localparam int MODE_W = 12;

   logic [MODE_W-1:0] core;

   // reserved (11:10), write burst (9), op mode (8:7), CL (6:4), BT (3), BL (2:0)
   assign core = {2'b00, WRITE_BURST, 2'b00, CAS_LAT, BURST_TYPE, BL_CODE};

   generate
      if (ADDR_W > MODE_W) begin : g_pad
         assign word = {{(ADDR_W-MODE_W){1'b0}}, core};
      end else begin : g_exact
         assign word = core[ADDR_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
   import sdram_init_pkg::*;
#(
   parameter int CNT_W   = 13,
   parameter int PWR_CYC = 5000,
   parameter int RP_CYC  = 2,
   parameter int RC_CYC  = 4,
   parameter int MRD_CYC = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clk_stable,
   input  logic             tmr_expired,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output init_state_e      state
);

   localparam logic [CNT_W-1:0] PWR_LOAD = CNT_W'(PWR_CYC - 1);
   localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(RP_CYC - 2);
   localparam logic [CNT_W-1:0] RC_LOAD  = CNT_W'(RC_CYC - 2);
   localparam logic [CNT_W-1:0] MRD_LOAD = CNT_W'(MRD_CYC - 2);

   init_state_e state_q, state_d;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         S_WAIT_CLK: if (clk_stable) begin
            state_d  = S_POWERUP;
            tmr_load = 1'b1;
            tmr_val  = PWR_LOAD;
         end
         S_POWERUP:   if (tmr_expired) state_d = S_PRECHARGE;
         S_PRECHARGE: begin
            state_d  = S_WAIT_RP;
            tmr_load = 1'b1;
            tmr_val  = RP_LOAD;
         end
         S_WAIT_RP:   if (tmr_expired) state_d = S_REF_A;
         S_REF_A: begin
            state_d  = S_WAIT_RC_A;
            tmr_load = 1'b1;
            tmr_val  = RC_LOAD;
         end
         S_WAIT_RC_A: if (tmr_expired) state_d = S_REF_B;
         S_REF_B: begin
            state_d  = S_WAIT_RC_B;
            tmr_load = 1'b1;
            tmr_val  = RC_LOAD;
         end
         S_WAIT_RC_B: if (tmr_expired) state_d = S_LOAD_MODE;
         S_LOAD_MODE: begin
            state_d  = S_WAIT_MRD;
            tmr_load = 1'b1;
            tmr_val  = MRD_LOAD;
         end
         S_WAIT_MRD:  if (tmr_expired) state_d = S_READY;
         S_READY:     state_d = S_READY;
         default:     state_d = S_WAIT_CLK;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= S_WAIT_CLK;
      else     state_q <= state_d;
   end

   assign state = state_q;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
   import sdram_init_pkg::*;
#(
   parameter int         CLK_MHZ      = 50,
   parameter int         T_POWERUP_NS = 100_000,
   parameter int         T_RP_NS      = 20,
   parameter int         T_RC_NS      = 70,
   parameter int         T_MRD_CYC    = 2,
   parameter int         ADDR_W       = 12,
   parameter int         BANK_W       = 2,
   parameter int         AP_BIT       = 10,
   parameter logic [2:0] BL_CODE      = 3'd3,
   parameter logic       BURST_TYPE   = 1'b0,
   parameter logic [2:0] CAS_LAT      = 3'd3,
   parameter logic       WRITE_BURST  = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clk_stable,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [ADDR_W-1:0] sd_addr,
   output logic [BANK_W-1:0] sd_bank,
   output logic              init_done
);

   localparam int PWR_CYC = ns_to_cycles(T_POWERUP_NS, CLK_MHZ, 1);
   localparam int RP_CYC  = ns_to_cycles(T_RP_NS, CLK_MHZ, 2);
   localparam int RC_CYC  = ns_to_cycles(T_RC_NS, CLK_MHZ, 2);
   localparam int MAX_A   = (PWR_CYC > RP_CYC) ? PWR_CYC : RP_CYC;
   localparam int MAX_B   = (RC_CYC > T_MRD_CYC) ? RC_CYC : T_MRD_CYC;
   localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 12) begin : g_bad_addr
         $error("ADDR_W must hold the 12-bit mode word");
      end
      if (AP_BIT >= ADDR_W) begin : g_bad_ap
         $error("AP_BIT outside the address bus");
      end
      if (BANK_W < 1) begin : g_bad_bank
         $error("BANK_W must be at least 1");
      end
      if (T_MRD_CYC < 2) begin : g_bad_mrd
         $error("T_MRD_CYC must be at least 2");
      end
      if (CLK_MHZ < 1) begin : g_bad_clk
         $error("CLK_MHZ must be positive");
      end
      if (!(BL_CODE <= 3'd3 || (BL_CODE == 3'd7 && BURST_TYPE == 1'b0))) begin : g_bad_bl
         $error("burst length code reserved for this burst type");
      end
      if (CAS_LAT < 3'd1 || CAS_LAT > 3'd3) begin : g_bad_cl
         $error("CAS latency code reserved");
      end
   endgenerate

   init_state_e      state;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;
   logic [ADDR_W-1:0] mode_word;
   sd_cmd_t          cmd;

   sdram_init_timer #(.CNT_W(CNT_W)) timer_i (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   sdram_init_fsm #(
      .CNT_W   (CNT_W),
      .PWR_CYC (PWR_CYC),
      .RP_CYC  (RP_CYC),
      .RC_CYC  (RC_CYC),
      .MRD_CYC (T_MRD_CYC)
   ) fsm_i (
      .clk         (clk),
      .rst         (rst),
      .clk_stable  (clk_stable),
      .tmr_expired (tmr_expired),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .state       (state)
   );

   sdram_init_mode_word #(
      .ADDR_W      (ADDR_W),
      .BL_CODE     (BL_CODE),
      .BURST_TYPE  (BURST_TYPE),
      .CAS_LAT     (CAS_LAT),
      .WRITE_BURST (WRITE_BURST)
   ) mode_i (
      .word (mode_word)
   );

   always_comb begin
      cmd     = CMD_NOP;
      sd_addr = '0;
      unique case (state)
         S_WAIT_CLK:  cmd = CMD_INHIBIT;
         S_PRECHARGE: begin
            cmd             = CMD_PRECHARGE;
            sd_addr[AP_BIT] = 1'b1;
         end
         S_REF_A,
         S_REF_B:     cmd = CMD_REFRESH;
         S_LOAD_MODE: begin
            cmd     = CMD_LOAD_MODE;
            sd_addr = mode_word;
         end
         default:     cmd = CMD_NOP;
      endcase
   end

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
   assign sd_bank   = '0;
   assign init_done = (state == S_READY);

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
   parameter int T_MRD_CYC = 2,
   parameter int ADDR_W    = 12,
   parameter int AP_BIT    = 10
) (
   input logic              clk,
   input logic              rst,
   input logic              sd_cs_n,
   input logic              sd_ras_n,
   input logic              sd_cas_n,
   input logic              sd_we_n,
   input logic [ADDR_W-1:0] sd_addr,
   input logic              init_done
);

   logic [3:0] cmd;
   logic       is_pre, is_ref, is_lmr, is_nop;
   logic [1:0] ref_cnt;
   logic       pre_seen;
   int         since_lmr;

   assign cmd    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
   assign is_pre = (cmd == 4'b0010);
   assign is_ref = (cmd == 4'b0001);
   assign is_lmr = (cmd == 4'b0000);
   assign is_nop = (cmd == 4'b0111);

   always_ff @(posedge clk) begin
      if (rst) begin
         ref_cnt   <= '0;
         pre_seen  <= 1'b0;
         since_lmr <= 0;
      end else begin
         if (is_ref && ref_cnt != 2'd3) ref_cnt <= ref_cnt + 1'b1;
         if (is_pre) pre_seen <= 1'b1;
         if (is_lmr) since_lmr <= 1;
         else if (since_lmr != 0 && since_lmr < 1000) since_lmr <= since_lmr + 1;
      end
   end

   a_r1_inhibit_after_reset: assert property (@(posedge clk)
      rst |=> (sd_cs_n && !init_done));

   a_r3_precharge_all: assert property (@(posedge clk) disable iff (rst)
      is_pre |-> sd_addr[AP_BIT]);

   a_r5_refresh_after_precharge: assert property (@(posedge clk) disable iff (rst)
      is_ref |-> pre_seen);

   a_r6_load_after_two_refresh: assert property (@(posedge clk) disable iff (rst)
      is_lmr |-> (ref_cnt == 2'd2));

   a_r6_zero_fields: assert property (@(posedge clk) disable iff (rst)
      is_lmr |-> (sd_addr[8:7] == 2'b00 && sd_addr[11:10] == 2'b00));

   a_r7_done_spacing: assert property (@(posedge clk) disable iff (rst)
      $rose(init_done) |-> (since_lmr == T_MRD_CYC));

   a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);

   a_r8_done_nop: assert property (@(posedge clk) disable iff (rst)
      init_done |-> is_nop);

endmodule

bind sdram_init_seq sdram_init_chk #(
   .T_MRD_CYC (T_MRD_CYC),
   .ADDR_W    (ADDR_W),
   .AP_BIT    (AP_BIT)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .sd_cs_n   (sd_cs_n),
   .sd_ras_n  (sd_ras_n),
   .sd_cas_n  (sd_cas_n),
   .sd_we_n   (sd_we_n),
   .sd_addr   (sd_addr),
   .init_done (init_done)
);

// File: tb/sdram_init_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_init_seq_tb_top;

   localparam int MHZ    = 50;
   localparam int PWR_NS = 100_000;
   localparam int RP_NS  = 20;
   localparam int RC_NS  = 70;
   localparam int MRD    = 2;

   // expected counts from the requirement formulas
   localparam int E_PWR_RAW = (PWR_NS * MHZ + 999) / 1000;
   localparam int E_PWR     = (E_PWR_RAW < 1) ? 1 : E_PWR_RAW;
   localparam int E_RP_RAW  = (RP_NS * MHZ + 999) / 1000;
   localparam int E_RP      = (E_RP_RAW < 2) ? 2 : E_RP_RAW;
   localparam int E_RC_RAW  = (RC_NS * MHZ + 999) / 1000;
   localparam int E_RC      = (E_RC_RAW < 2) ? 2 : E_RC_RAW;
   // burst length code 2, interleaved, CAS 2, single-write mode
   localparam logic [11:0] E_MODE = 12'h22A;

   localparam logic [3:0] C_INH = 4'b1111;
   localparam logic [3:0] C_NOP = 4'b0111;
   localparam logic [3:0] C_PRE = 4'b0010;
   localparam logic [3:0] C_REF = 4'b0001;
   localparam logic [3:0] C_LMR = 4'b0000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        clk_stable = 1'b0;
   logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [11:0] sd_addr;
   logic [1:0]  sd_bank;
   logic        init_done;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit compare_on = 1'b0;

   always #10 clk = ~clk;

   sdram_init_seq #(
      .CLK_MHZ      (MHZ),
      .T_POWERUP_NS (PWR_NS),
      .T_RP_NS      (RP_NS),
      .T_RC_NS      (RC_NS),
      .T_MRD_CYC    (MRD),
      .ADDR_W       (12),
      .BANK_W       (2),
      .AP_BIT       (10),
      .BL_CODE      (3'd2),
      .BURST_TYPE   (1'b1),
      .CAS_LAT      (3'd2),
      .WRITE_BURST  (1'b1)
   ) dut_i (
      .clk        (clk),
      .rst        (rst),
      .clk_stable (clk_stable),
      .sd_cs_n    (sd_cs_n),
      .sd_ras_n   (sd_ras_n),
      .sd_cas_n   (sd_cas_n),
      .sd_we_n    (sd_we_n),
      .sd_addr    (sd_addr),
      .sd_bank    (sd_bank),
      .init_done  (init_done)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // ---------------- reference model ----------------
   bit          m_started = 1'b0;
   logic [3:0]  q_cmd[$];
   logic [11:0] q_addr[$];
   string       q_tag[$];

   task automatic push(input logic [3:0] c, input logic [11:0] a, input string t, input int n);
      for (int i = 0; i < n; i++) begin
         q_cmd.push_back(c);
         q_addr.push_back(a);
         q_tag.push_back(t);
      end
   endtask

   task automatic build_schedule();
      push(C_NOP, 12'h000, "R2", E_PWR);
      push(C_PRE, 12'h400, "R3", 1);
      push(C_NOP, 12'h000, "R4", E_RP - 1);
      push(C_REF, 12'h000, "R5", 1);
      push(C_NOP, 12'h000, "R5", E_RC - 1);
      push(C_REF, 12'h000, "R5", 1);
      push(C_NOP, 12'h000, "R5", E_RC - 1);
      push(C_LMR, E_MODE,  "R6", 1);
      push(C_NOP, 12'h000, "R7", MRD - 1);
   endtask

   always @(posedge clk) begin
      compare_on <= 1'b1;
      if (rst) begin
         m_started = 1'b0;
         q_cmd.delete();
         q_addr.delete();
         q_tag.delete();
      end else if (!m_started) begin
         if (clk_stable) begin
            m_started = 1'b1;
            build_schedule();
         end
      end else if (q_cmd.size() > 0) begin
         void'(q_cmd.pop_front());
         void'(q_addr.pop_front());
         void'(q_tag.pop_front());
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      logic [3:0]  ec;
      logic [11:0] ea;
      logic        ed;
      string       tg;
      if (compare_on) begin
         if (!m_started) begin
            ec = C_INH; ea = '0; ed = 1'b0; tg = "R1";
         end else if (q_cmd.size() > 0) begin
            ec = q_cmd[0]; ea = q_addr[0]; ed = 1'b0; tg = q_tag[0];
         end else begin
            ec = C_NOP; ea = '0; ed = 1'b1; tg = "R8";
         end
         check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} === ec, {tg, " cmd"},
               int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(ec));
         check(sd_addr === ea, {tg, " addr"}, int'(sd_addr), int'(ea));
         check(sd_bank === 2'b00, {tg, " bank"}, int'(sd_bank), 0);
         check(init_done === ed, {tg, " done"}, int'(init_done), int'(ed));
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150_000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         finish_run();
      end
   end

   task automatic cycles_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   localparam int E_TOTAL = E_PWR + E_RP + 2 * E_RC + MRD;

   initial begin
      int n;
      int refs;

      // R1: reset held, then clock not yet stable
      cycles_n(5);
      rst = 1'b0;
      cycles_n(20);
      check(sd_cs_n === 1'b1 && init_done === 1'b0, "R1 inhibit before stable",
            int'({sd_cs_n, init_done}), 2);

      // full sequence; R2..R7 checked per cycle by the model
      clk_stable = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (init_done !== 1'b1 && n < 20000);
      check(n == E_TOTAL + 1, "R7 done timing", n, E_TOTAL + 1);
      cycles_n(30);
      check(init_done === 1'b1, "R8 done holds", int'(init_done), 1);

      // R10: reset after done, release together with clk_stable high
      rst = 1'b1;
      cycles_n(3);
      check(init_done === 1'b0 && sd_cs_n === 1'b1, "R10 reset after done",
            int'({sd_cs_n, init_done}), 2);
      rst = 1'b0;

      // R10: reset on the cycle the second refresh is on the bus
      refs = 0;
      n = 0;
      while (refs < 2 && n < 20000) begin
         @(negedge clk);
         n++;
         if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} === C_REF) refs++;
      end
      check(refs == 2, "R5 two refreshes seen", refs, 2);
      rst = 1'b1;
      cycles_n(2);
      rst = 1'b0;

      // R10 full power-up wait again; R9 clk_stable drop mid-wait
      n = 0;
      while (n < 20000) begin
         @(negedge clk);
         if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} !== C_NOP) break;
         n++;
         if (n == 100) clk_stable = 1'b0;
      end
      check(n == E_PWR, "R10 restart power-up length", n, E_PWR);
      check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} === C_PRE, "R9 sequence continues",
            int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(C_PRE));
      n = 0;
      while (init_done !== 1'b1 && n < 200) begin @(negedge clk); n++; end
      check(init_done === 1'b1, "R9 done without clk_stable", int'(init_done), 1);

      // R1 again: reset with clock unstable keeps inhibit
      rst = 1'b1;
      cycles_n(2);
      rst = 1'b0;
      cycles_n(15);
      check(sd_cs_n === 1'b1 && init_done === 1'b0, "R1 inhibit after reset",
            int'({sd_cs_n, init_done}), 2);
      clk_stable = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (init_done !== 1'b1 && n < 20000);
      check(n == E_TOTAL + 1, "R7 done timing rerun", n, E_TOTAL + 1);
      cycles_n(5);

      finish_run();
   end

endmodule